// File: doc/BRIEF.md
# Battery-Backed SRAM Block Mover

This block moves data between an external byte-wide asynchronous SRAM, kept alive by a battery, and an on-chip byte-wide block RAM. The host never writes the external SRAM directly. It stages data in the block RAM, then asks this block to copy one 2 KB block in either direction. The external SRAM holds four such banks (8 KB). Host control goes through four 16-bit registers that report progress and power-fail state and accept direction, bank, start and flag-clear.

An active-low power-fail input is synchronized and latched into a sticky flag. A copy that is already running when power fails always runs to its last byte. No new copy can start until software clears the flag. While a copy runs, the block owns the block RAM port. Host requests to the block RAM window are held off and flagged as stalled. While the block is idle, those requests pass straight through.

The time per byte is a parameter, `STEP_CYC`, given in clock cycles. The default of 32 cycles at a 49.5 MHz clock gives 65,536 cycles, about 1.32 ms, for a full block.

Top module: `bbsram_mover`

## Requirements
- R1: After reset, every register reads 0. The SRAM strobes `sram_ce_n`, `sram_oe_n` and `sram_we_n` are high, `sram_dq_oe` is 0 and `hb_stall` is 0.
- R2: The register index `reg_addr` selects one of four registers:
  - 0 is status: bit 0 busy, bit 1 power-fail flag.
  - 1 is control: bit 0 direction, bits 2:1 bank. It reads back what was written.
  - 2 is enable: bit 0 only. It reads back what was written.
  - 3 is the flag-clear register.
  - Unimplemented bits read 0. Reads are valid while `reg_cs`=1 and `reg_wr`=0.
- R3: A copy starts only on a 0-to-1 change of the enable bit, seen while idle with no power fail. Busy reads 1 from the second clock edge after the enable write. If enable is left at 1 after a copy ends, no further copy starts.
- R4: Direction 0 copies bytes 0..2047 of the selected SRAM bank to block RAM offsets 0..2047.
- R5: Direction 1 copies block RAM offsets 0..2047 into the selected SRAM bank.
- R6: Every SRAM access uses the address {bank, 11-bit offset}. Banks other than the selected one are left unchanged.
- R7: Busy stays 1 for exactly 2048 × `STEP_CYC` clock cycles.
- R8: `sram_we_n` is low only while `sram_dq_oe`=1 and `sram_oe_n`=1. Address and write data do not change while it is low. `sram_oe_n` is low only in direction-0 copies, never together with `sram_dq_oe`. Each byte of a direction-1 copy gets exactly one write pulse.
- R9: A low on `pf_n` passes through a two-flop synchronizer and sets the status power-fail flag. The flag is set by the third clock edge. It stays set after `pf_n` returns high. Only a write of 0 to register 3 clears it; a nonzero write there has no effect.
- R10: A copy running when power fails completes all 2048 bytes. While the flag is set, an enable 0-to-1 change starts nothing.
- R11: After the flag is cleared, an enable bit that is already 1 starts nothing. A fresh 0-to-1 change is needed.
- R12: While busy, host block RAM requests (`hb_en`) do not reach the block RAM, and `hb_stall` is 1. While idle they pass through and `hb_stall` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_cs | input | 1 | Register access select |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pf_n | input | 1 | Power-fail input, active low, asynchronous |
| sram_addr | output | 13 | SRAM address {bank, offset} |
| sram_dq_i | input | 8 | SRAM read data |
| sram_dq_o | output | 8 | SRAM write data |
| sram_dq_oe | output | 1 | Drive enable for SRAM data pins |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| bram_en | output | 1 | Block RAM access enable |
| bram_we | output | 1 | Block RAM write enable |
| bram_addr | output | 11 | Block RAM byte address |
| bram_wdata | output | 8 | Block RAM write data |
| bram_rdata | input | 8 | Block RAM read data, one cycle after enable |
| hb_en | input | 1 | Host block RAM request |
| hb_we | input | 1 | Host block RAM write |
| hb_addr | input | 11 | Host block RAM address |
| hb_wdata | input | 8 | Host block RAM write data |
| hb_stall | output | 1 | Host request held off by a running copy |

## Verification
Register writes land on the clock edge inside the write task, and read data is combinational. Busy therefore shows at the second falling edge after an enable write. The power-fail flag shows at the third falling edge after `pf_n` falls, so the bench reads status at those points and no earlier.

Copy length is measured by counting every falling edge at which status shows busy, and is compared against 2048 × `STEP_CYC`. Memory contents are compared only after busy has been seen low. The no-start checks (enable held high, flag set, flag just cleared) watch busy over a window of ten cycles or more, which is longer than the two-edge start latency.

// File: rtl/bbm_pkg.sv
`timescale 1ns/1ps
package bbm_pkg;

  // Register indices on the host port; the software sequence relies on these.
  typedef enum logic [1:0] {
    RIX_STATUS = 2'd0,
    RIX_CTRL   = 2'd1,
    RIX_ENABLE = 2'd2,
    RIX_PFCLR  = 2'd3
  } reg_ix_e;

  // Copy direction, control bit 0.
  typedef enum logic {
    DIR_TO_BRAM = 1'b0,
    DIR_TO_SRAM = 1'b1
  } dir_e;

  localparam int unsigned STAT_BUSY_BIT = 0;
  localparam int unsigned STAT_PF_BIT   = 1;

endpackage

// File: rtl/bbm_pfail.sv
`timescale 1ns/1ps
module bbm_pfail #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pf_n_i,
  input  logic clr_i,
  output logic pf_now_o,
  output logic flag_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   flag_q;
  logic                   flag_d;

  // Synchronizer chain, asserted-high internally.
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign sync_d[g] = ~pf_n_i;
    end else begin : g_next
      assign sync_d[g] = sync_q[g-1];
    end
  end

  assign pf_now_o = sync_q[SYNC_STAGES-1];

  always_comb begin
    flag_d = flag_q;
    if (pf_now_o) begin
      flag_d = 1'b1;          // a live power fail wins over a clear
    end else if (clr_i) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/bbm_regs.sv
`timescale 1ns/1ps
module bbm_regs
  import bbm_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_cs,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              busy_i,
  input  logic              pf_flag_i,
  input  logic              pf_block_i,
  output logic              dir_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              pf_clr_o,
  output logic              start_o
);

  localparam int unsigned CTRL_W = BANK_W + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_ld;
  logic              en_q;
  logic              en_d;
  logic              en_ld;
  logic              en_prev_q;
  logic              wr_hit;

  assign wr_hit   = reg_cs & reg_wr;
  assign ctrl_ld  = wr_hit & (reg_addr == RIX_CTRL);
  assign en_ld    = wr_hit & (reg_addr == RIX_ENABLE);
  assign ctrl_d   = reg_wdata[CTRL_W-1:0];
  assign en_d     = reg_wdata[0];
  assign pf_clr_o = wr_hit & (reg_addr == RIX_PFCLR) & (reg_wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      en_q      <= 1'b0;
      en_prev_q <= 1'b0;
    end else begin
      if (ctrl_ld) ctrl_q <= ctrl_d;
      if (en_ld)   en_q   <= en_d;
      en_prev_q <= en_q;
    end
  end

  // Edge of the enable bit; consumed whether or not the copy may start.
  assign start_o = en_q & ~en_prev_q & ~busy_i & ~pf_block_i;

  assign dir_o  = ctrl_q[0];
  assign bank_o = ctrl_q[CTRL_W-1:1];

  always_comb begin
    reg_rdata = '0;
    if (reg_cs && !reg_wr) begin
      case (reg_addr)
        RIX_STATUS: begin
          reg_rdata[STAT_BUSY_BIT] = busy_i;
          reg_rdata[STAT_PF_BIT]   = pf_flag_i;
        end
        RIX_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl_q;
        RIX_ENABLE: reg_rdata[0] = en_q;
        default:    reg_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/bbm_seq.sv
`timescale 1ns/1ps
module bbm_seq #(
  parameter int unsigned OFS_W    = 11,
  parameter int unsigned BANK_W   = 2,
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned STEP_CYC = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    dir_i,
  input  logic [BANK_W-1:0]       bank_i,
  output logic                    busy_o,
  output logic [BANK_W+OFS_W-1:0] sram_addr_o,
  input  logic [BYTE_W-1:0]       sram_dq_i,
  output logic [BYTE_W-1:0]       sram_dq_o,
  output logic                    sram_dq_oe_o,
  output logic                    sram_ce_n_o,
  output logic                    sram_oe_n_o,
  output logic                    sram_we_n_o,
  output logic                    bram_en_o,
  output logic                    bram_we_o,
  output logic [OFS_W-1:0]        bram_addr_o,
  output logic [BYTE_W-1:0]       bram_wdata_o,
  input  logic [BYTE_W-1:0]       bram_rdata_i
);

  // Phase plan for a write step: 0 read bram, 1 capture byte,
  // 2.. drive bus, 3..STEP-2 write strobe, STEP-1 hold.
  localparam int unsigned PH_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [PH_W-1:0]  PH_RD     = '0;
  localparam logic [PH_W-1:0]  PH_CAP    = PH_W'(1);
  localparam logic [PH_W-1:0]  PH_DRV    = PH_W'(2);
  localparam logic [PH_W-1:0]  PH_WE_LO  = PH_W'(3);
  localparam logic [PH_W-1:0]  PH_WE_HI  = PH_W'(STEP_CYC - 2);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(STEP_CYC - 1);
  localparam logic [OFS_W-1:0] OFS_LAST  = '1;

  logic              busy_q, busy_d;
  logic [PH_W-1:0]   ph_q, ph_d;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic              dir_q, dir_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [BYTE_W-1:0] byte_q;
  logic              byte_ld;
  logic              step_end;
  logic              wr_copy;
  logic              rd_copy;

  assign step_end = busy_q & (ph_q == PH_LAST);
  assign wr_copy  = busy_q & dir_q;
  assign rd_copy  = busy_q & ~dir_q;
  assign byte_ld  = wr_copy & (ph_q == PH_CAP);

  always_comb begin
    busy_d = busy_q;
    ph_d   = ph_q;
    ofs_d  = ofs_q;
    dir_d  = dir_q;
    bank_d = bank_q;
    if (!busy_q) begin
      ph_d  = '0;
      ofs_d = '0;
      if (start_i) begin
        busy_d = 1'b1;
        dir_d  = dir_i;     // configuration is frozen for the whole copy
        bank_d = bank_i;
      end
    end else if (step_end) begin
      ph_d  = '0;
      ofs_d = ofs_q + 1'b1;
      if (ofs_q == OFS_LAST) begin
        busy_d = 1'b0;
      end
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      ofs_q  <= '0;
      dir_q  <= 1'b0;
      bank_q <= '0;
      byte_q <= '0;
    end else begin
      busy_q <= busy_d;
      ph_q   <= ph_d;
      ofs_q  <= ofs_d;
      dir_q  <= dir_d;
      bank_q <= bank_d;
      if (byte_ld) byte_q <= bram_rdata_i;
    end
  end

  assign busy_o       = busy_q;
  assign sram_addr_o  = {bank_q, ofs_q};
  assign sram_ce_n_o  = ~busy_q;
  assign sram_oe_n_o  = ~rd_copy;
  assign sram_dq_oe_o = wr_copy & (ph_q >= PH_DRV);
  assign sram_we_n_o  = ~(wr_copy & (ph_q >= PH_WE_LO) & (ph_q <= PH_WE_HI));
  assign sram_dq_o    = byte_q;

  assign bram_en_o    = (wr_copy & (ph_q == PH_RD)) | (rd_copy & step_end);
  assign bram_we_o    = rd_copy & step_end;
  assign bram_addr_o  = ofs_q;
  assign bram_wdata_o = sram_dq_i;

endmodule

// File: rtl/bbsram_mover.sv
`timescale 1ns/1ps
module bbsram_mover
  import bbm_pkg::*;
#(
  parameter int unsigned OFS_W       = 11,
  parameter int unsigned BANK_W      = 2,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned REG_W       = 16,
  parameter int unsigned STEP_CYC    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_cs,
  input  logic                    reg_wr,
  input  logic [1:0]              reg_addr,
  input  logic [REG_W-1:0]        reg_wdata,
  output logic [REG_W-1:0]        reg_rdata,
  input  logic                    pf_n,
  output logic [BANK_W+OFS_W-1:0] sram_addr,
  input  logic [BYTE_W-1:0]       sram_dq_i,
  output logic [BYTE_W-1:0]       sram_dq_o,
  output logic                    sram_dq_oe,
  output logic                    sram_ce_n,
  output logic                    sram_oe_n,
  output logic                    sram_we_n,
  output logic                    bram_en,
  output logic                    bram_we,
  output logic [OFS_W-1:0]        bram_addr,
  output logic [BYTE_W-1:0]       bram_wdata,
  input  logic [BYTE_W-1:0]       bram_rdata,
  input  logic                    hb_en,
  input  logic                    hb_we,
  input  logic [OFS_W-1:0]        hb_addr,
  input  logic [BYTE_W-1:0]       hb_wdata,
  output logic                    hb_stall
);

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              busy;
  logic              pf_flag;
  logic              pf_now;
  logic              pf_clr;
  logic              start;
  logic              cfg_dir;
  logic [BANK_W-1:0] cfg_bank;
  logic              seq_bram_en;
  logic              seq_bram_we;
  logic [OFS_W-1:0]  seq_bram_addr;
  logic [BYTE_W-1:0] seq_bram_wdata;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  bbm_pfail #(.SYNC_STAGES(SYNC_STAGES)) u_pfail (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .pf_n_i   (pf_n),
    .clr_i    (pf_clr),
    .pf_now_o (pf_now),
    .flag_o   (pf_flag)
  );

  bbm_regs #(.REG_W(REG_W), .BANK_W(BANK_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .reg_cs     (reg_cs),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .busy_i     (busy),
    .pf_flag_i  (pf_flag),
    .pf_block_i (pf_flag | pf_now),
    .dir_o      (cfg_dir),
    .bank_o     (cfg_bank),
    .pf_clr_o   (pf_clr),
    .start_o    (start)
  );

  bbm_seq #(
    .OFS_W(OFS_W), .BANK_W(BANK_W), .BYTE_W(BYTE_W), .STEP_CYC(STEP_CYC)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_i      (start),
    .dir_i        (cfg_dir),
    .bank_i       (cfg_bank),
    .busy_o       (busy),
    .sram_addr_o  (sram_addr),
    .sram_dq_i    (sram_dq_i),
    .sram_dq_o    (sram_dq_o),
    .sram_dq_oe_o (sram_dq_oe),
    .sram_ce_n_o  (sram_ce_n),
    .sram_oe_n_o  (sram_oe_n),
    .sram_we_n_o  (sram_we_n),
    .bram_en_o    (seq_bram_en),
    .bram_we_o    (seq_bram_we),
    .bram_addr_o  (seq_bram_addr),
    .bram_wdata_o (seq_bram_wdata),
    .bram_rdata_i (bram_rdata)
  );

  // Block RAM port ownership: the copy engine wins while busy.
  always_comb begin
    if (busy) begin
      bram_en    = seq_bram_en;
      bram_we    = seq_bram_we;
      bram_addr  = seq_bram_addr;
      bram_wdata = seq_bram_wdata;
    end else begin
      bram_en    = hb_en;
      bram_we    = hb_en & hb_we;
      bram_addr  = hb_addr;
      bram_wdata = hb_wdata;
    end
  end

  assign hb_stall = busy & hb_en;

endmodule

// File: rtl/bbm_chk.sv
`timescale 1ns/1ps
module bbm_chk #(
  parameter int unsigned SA_W   = 13,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned REG_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              pf_flag,
  input logic              reg_cs,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [SA_W-1:0]   sram_addr,
  input logic [BYTE_W-1:0] sram_dq_o,
  input logic              sram_dq_oe,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              hb_en,
  input logic              hb_stall
);

  logic clr_wr;
  assign clr_wr = reg_cs & reg_wr & (reg_addr == 2'd3) & (reg_wdata == '0);

  p_we_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_dq_oe && sram_oe_n && !sram_ce_n));

  p_we_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && !$past(sram_we_n)) |-> ($stable(sram_dq_o) && $stable(sram_addr)));

  p_oe_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_dq_oe && sram_we_n));

  p_no_start_pf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(pf_flag));

  p_pf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_flag && !clr_wr) |=> pf_flag);

  p_stall_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hb_en) |-> hb_stall);

  p_stall_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !hb_stall);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sram_ce_n |-> (sram_we_n && sram_oe_n && !sram_dq_oe));

endmodule

bind bbsram_mover bbm_chk #(
  .SA_W(BANK_W + OFS_W), .BYTE_W(BYTE_W), .REG_W(REG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .busy       (busy),
  .pf_flag    (pf_flag),
  .reg_cs     (reg_cs),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .sram_addr  (sram_addr),
  .sram_dq_o  (sram_dq_o),
  .sram_dq_oe (sram_dq_oe),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .hb_en      (hb_en),
  .hb_stall   (hb_stall)
);

// File: tb/sim_bbsram_mover.sv
`timescale 1ns/1ps
module sim_bbsram_mover;

  localparam int STEP   = 6;
  localparam int NBYTE  = 2048;
  localparam int NSRAM  = 8192;
  localparam int COPY_N = NBYTE * STEP;

  logic        clk;
  logic        rst_n;
  logic        reg_cs, reg_wr;
  logic [1:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        pf_n;
  logic [12:0] sram_addr;
  logic [7:0]  sram_dq_i, sram_dq_o;
  logic        sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;
  logic        bram_en, bram_we;
  logic [10:0] bram_addr;
  logic [7:0]  bram_wdata, bram_rdata;
  logic        hb_en, hb_we;
  logic [10:0] hb_addr;
  logic [7:0]  hb_wdata;
  logic        hb_stall;

  logic [7:0] sram_mem [0:NSRAM-1];
  logic [7:0] exp_sram [0:NSRAM-1];
  logic [7:0] bram_mem [0:NBYTE-1];

  int  n_chk, n_fail;
  int  sviol, we_pulses;
  logic run_ok, prev_we_low;
  logic [12:0] prev_addr;
  logic [7:0]  prev_dq;

  bbsram_mover #(.STEP_CYC(STEP)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_cs(reg_cs), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pf_n(pf_n), .sram_addr(sram_addr), .sram_dq_i(sram_dq_i),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_ce_n(sram_ce_n),
    .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .bram_en(bram_en),
    .bram_we(bram_we), .bram_addr(bram_addr), .bram_wdata(bram_wdata),
    .bram_rdata(bram_rdata), .hb_en(hb_en), .hb_we(hb_we),
    .hb_addr(hb_addr), .hb_wdata(hb_wdata), .hb_stall(hb_stall)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural asynchronous SRAM: write latched at the rising write strobe.
  always @(posedge sram_we_n) begin
    if (run_ok && !sram_ce_n) sram_mem[sram_addr] = sram_dq_o;
  end
  assign sram_dq_i = (!sram_ce_n && !sram_oe_n) ? sram_mem[sram_addr] : 8'h00;

  // Block RAM with one-cycle read latency (read-before-write).
  always @(posedge clk) begin
    if (bram_en) begin
      bram_rdata <= bram_mem[bram_addr];
      if (bram_we) bram_mem[bram_addr] = bram_wdata;
    end
  end

  // Strobe discipline monitor (R8).
  always @(negedge clk) begin
    if (run_ok) begin
      if (!sram_we_n && (!sram_oe_n || !sram_dq_oe || sram_ce_n)) sviol++;
      if (!sram_oe_n && sram_dq_oe) sviol++;
      if (!sram_we_n && prev_we_low && (sram_addr != prev_addr || sram_dq_o != prev_dq)) sviol++;
      if (!sram_we_n && !prev_we_low) we_pulses++;
      prev_we_low = !sram_we_n;
      prev_addr   = sram_addr;
      prev_dq     = sram_dq_o;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] ix, input logic [15:0] v);
    @(negedge clk);
    reg_cs = 1'b1; reg_wr = 1'b1; reg_addr = ix; reg_wdata = v;
    @(negedge clk);
    reg_cs = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [1:0] ix, output logic [15:0] v);
    reg_cs = 1'b1; reg_wr = 1'b0; reg_addr = ix;
    #1;
    v = reg_rdata;
    reg_cs = 1'b0;
  endtask

  // Counts falling edges at which status shows busy; stops at first idle read.
  task automatic wait_idle(output int cyc);
    logic [15:0] v;
    cyc = 0;
    for (int i = 0; i < COPY_N + 100; i++) begin
      @(negedge clk);
      reg_read(2'd0, v);
      if (!v[0]) break;
      cyc++;
    end
  endtask

  task automatic snapshot_sram();
    for (int a = 0; a < NSRAM; a++) exp_sram[a] = sram_mem[a];
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk);
    reg_read(2'd0, v); chk("R1 status", {16'h0, v}, 32'h0);
    reg_read(2'd1, v); chk("R1 control", {16'h0, v}, 32'h0);
    reg_read(2'd2, v); chk("R1 enable", {16'h0, v}, 32'h0);
    chk("R1 strobes", {28'h0, sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe}, 32'he);
    chk("R1 stall", {31'h0, hb_stall}, 32'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    reg_write(2'd1, 16'h0005);
    reg_read(2'd1, v); chk("R2 control readback", {16'h0, v}, 32'h5);
    reg_write(2'd1, 16'hFFFF);
    reg_read(2'd1, v); chk("R2 control unused bits", {16'h0, v}, 32'h7);
    reg_write(2'd1, 16'h0000);
    reg_read(2'd3, v); chk("R2 clear register reads 0", {16'h0, v}, 32'h0);
  endtask

  task automatic t_host_pass();
    @(negedge clk);
    hb_en = 1'b1; hb_we = 1'b1; hb_addr = 11'd100; hb_wdata = 8'hA5;
    #1;
    chk("R12 idle no stall", {31'h0, hb_stall}, 32'h0);
    @(negedge clk);
    hb_en = 1'b0; hb_we = 1'b0;
    chk("R12 idle passthrough", {24'h0, bram_mem[100]}, 32'hA5);
  endtask

  task automatic t_to_sram();
    logic [15:0] v;
    int cyc, bad, other;
    for (int i = 0; i < NBYTE; i++) bram_mem[i] = 8'((i * 7 + 3) ^ (i >> 8));
    snapshot_sram();
    reg_write(2'd1, 16'h0003);                 // dir 1, bank 1
    reg_write(2'd2, 16'h0001);
    cyc = 0;
    for (int i = 0; i < COPY_N + 100; i++) begin
      @(negedge clk);
      hb_en = 1'b0; hb_we = 1'b0;
      reg_read(2'd0, v);
      if (i == 0) chk("R3 busy two edges after enable", {31'h0, v[0]}, 32'h1);
      if (!v[0]) break;
      cyc++;
      if (cyc == 10) begin
        reg_read(2'd2, v); chk("R2 enable readback", {16'h0, v}, 32'h1);
        hb_en = 1'b1; hb_we = 1'b1; hb_addr = 11'd5; hb_wdata = 8'hEE;
        #1;
        chk("R12 stall while busy", {31'h0, hb_stall}, 32'h1);
      end
    end
    chk("R7 copy length", cyc, COPY_N);
    bad = 0; other = 0;
    for (int i = 0; i < NBYTE; i++)
      if (sram_mem[2048 + i] !== bram_mem[i]) bad++;
    for (int a = 0; a < NSRAM; a++)
      if ((a >> 11) != 1 && sram_mem[a] !== exp_sram[a]) other++;
    chk("R5 bram to sram bank 1", bad, 0);
    chk("R6 other banks untouched", other, 0);
    chk("R12 host write blocked", {24'h0, bram_mem[5]}, {24'h0, 8'((5 * 7 + 3))});
    repeat (20) @(negedge clk);
    reg_read(2'd0, v); chk("R3 held enable no restart", {31'h0, v[0]}, 32'h0);
    reg_write(2'd2, 16'h0000);
  endtask

  task automatic t_to_bram();
    int cyc, bad, other;
    snapshot_sram();
    reg_write(2'd1, 16'h0006);                 // dir 0, bank 3
    reg_write(2'd2, 16'h0001);
    wait_idle(cyc);
    bad = 0; other = 0;
    for (int i = 0; i < NBYTE; i++)
      if (bram_mem[i] !== exp_sram[3 * 2048 + i]) bad++;
    for (int a = 0; a < NSRAM; a++)
      if (sram_mem[a] !== exp_sram[a]) other++;
    chk("R4 sram bank 3 to bram", bad, 0);
    chk("R6 read copy leaves sram", other, 0);
    reg_write(2'd2, 16'h0000);
  endtask

  task automatic t_pfail();
    logic [15:0] v;
    int cyc, bad;
    for (int i = 0; i < NBYTE; i++) bram_mem[i] = 8'(i * 13 + 1);
    reg_write(2'd1, 16'h0005);                 // dir 1, bank 2
    reg_write(2'd2, 16'h0001);
    repeat (NBYTE / 2 * STEP) @(negedge clk);
    pf_n = 1'b0;
    repeat (3) @(negedge clk);
    reg_read(2'd0, v); chk("R9 flag set mid copy", {16'h0, v}, 32'h3);
    pf_n = 1'b1;
    wait_idle(cyc);
    bad = 0;
    for (int i = 0; i < NBYTE; i++)
      if (sram_mem[2 * 2048 + i] !== bram_mem[i]) bad++;
    chk("R10 interrupted copy completes", bad, 0);
    reg_write(2'd2, 16'h0000);
    reg_write(2'd2, 16'h0001);
    repeat (12) @(negedge clk);
    reg_read(2'd0, v); chk("R10 no start while flagged", {16'h0, v}, 32'h2);
    reg_write(2'd3, 16'h0001);
    reg_read(2'd0, v); chk("R9 nonzero write keeps flag", {16'h0, v}, 32'h2);
    reg_write(2'd3, 16'h0000);
    reg_read(2'd0, v); chk("R9 zero write clears flag", {16'h0, v}, 32'h0);
    repeat (12) @(negedge clk);
    reg_read(2'd0, v); chk("R11 stale enable no start", {16'h0, v}, 32'h0);
    reg_write(2'd2, 16'h0000);
    reg_write(2'd2, 16'h0001);
    @(negedge clk);
    reg_read(2'd0, v); chk("R11 fresh edge starts", {16'h0, v}, 32'h1);
    wait_idle(cyc);
    reg_write(2'd2, 16'h0000);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    n_chk = 0; n_fail = 0; sviol = 0; we_pulses = 0;
    run_ok = 1'b0; prev_we_low = 1'b0; prev_addr = '0; prev_dq = '0;
    rst_n = 1'b0; pf_n = 1'b1;
    reg_cs = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    hb_en = 1'b0; hb_we = 1'b0; hb_addr = '0; hb_wdata = '0;
    for (int a = 0; a < NSRAM; a++) sram_mem[a] = 8'(a ^ (a >> 5) ^ 8'h5A);
    for (int i = 0; i < NBYTE; i++) bram_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_ok = 1'b1;
    t_reset();
    t_regs();
    t_host_pass();
    t_to_sram();
    t_to_bram();
    t_pfail();
    chk("R8 strobe discipline", sviol, 0);
    chk("R8 one write pulse per byte", we_pulses, 3 * NBYTE);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule